// File: doc/BRIEF.md
# Nine-Bit Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port. Its transmitter and receiver share one mode field, which selects an 8-bit frame or one of two 9-bit frames. In the 9-bit frames the extra bit acts as an address/data marker. The transmitter sends a control input as the ninth bit. The receiver keeps the ninth bit it received so software can read it. An optional multiprocessor filter drops incoming frames whose ninth bit is 0. A node on a shared line therefore sees only address frames until software turns the filter off.

Bit timing is built from a sampling strobe, and every bit lasts 16 strobes. In the externally timed modes the strobe comes from a 16x baud tick input. In the fixed-rate mode it comes from an internal clock divider. A doubling input selects the full strobe rate; otherwise every second strobe is used. The transmitter sets a done flag when the stop bit starts. The receiver sets a done flag when it accepts a frame. Software clears both flags through clear inputs.

Top module: `uart9_port`

## Requirements
- R1: After reset, `txd_o` is 1, both done flags are 0, `rx_data_o` is 0x00 and `rx_nine_o` is 0.
- R2: With `mode_i`=01, a pulse on `tx_wr_i` sends a 10-bit frame on `txd_o`: a 0 start bit, the 8 bits of `tx_data_i` least significant bit first, then a 1 stop bit.
- R3: With `mode_i`=10 or 11, the frame carries a ninth bit between the eighth data bit and the stop bit. That bit is the value of `tx_nine_i` captured at the write.
- R4: `tx_done_o` rises in the cycle the stop bit starts. It stays 0 during the data bits, stays set until `tx_clr_i` is pulsed, and then reads 0.
- R5: A write made while a frame is being sent is ignored. The frame in progress goes out unchanged, and no second frame follows it.
- R6: With `mode_i`=01 and `rx_en_i`=1, a received frame loads `rx_data_o` and sets `rx_done_o`. `rx_nine_o` keeps its value.
- R7: With `mode_i`=10 or 11, an accepted frame also stores its received ninth bit in `rx_nine_o`.
- R8: With `mode_i`=10 or 11 and `rx_mp_i`=1, a frame whose ninth bit is 0 is discarded: `rx_done_o`, `rx_data_o` and `rx_nine_o` do not change. With `rx_mp_i`=0, every frame is accepted.
- R9: With `mode_i`=01 and `rx_mp_i`=1, a frame whose stop bit reads 0 is discarded. With `rx_mp_i`=0 it is accepted.
- R10: While `rx_en_i`=0, no frame is started, and the receive outputs do not change.
- R11: A frame that completes while `rx_done_o` is still 1 is discarded, and `rx_data_o` keeps the earlier byte.
- R12: Each bit is decided by a 2-of-3 vote over strobes 7, 8 and 9 of its 16. A low pulse that has ended by mid-bit is a false start and produces no frame. A one-sample glitch inside a data bit does not change the received byte.
- R13: A bit lasts 16 strobes. In modes 01 and 11 the strobe is `tick16_i`; in mode 10 it fires once every `M2_DIV` clocks. When `dbl_i`=0 only every second strobe is used.
- R14: With `mode_i`=00, writes are ignored, `txd_o` stays 1 and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Frame mode: 00 off, 01 8-bit, 10 9-bit fixed rate, 11 9-bit tick rate |
| dbl_i | input | 1 | Rate doubling: 1 uses every strobe |
| tick16_i | input | 1 | External 16x baud tick |
| tx_wr_i | input | 1 | One-cycle write that starts a transmission |
| tx_data_i | input | DBITS | Byte to send |
| tx_nine_i | input | 1 | Ninth bit to send (1 address, 0 data) |
| tx_clr_i | input | 1 | Clears the transmit done flag |
| txd_o | output | 1 | Serial output, idle high |
| tx_done_o | output | 1 | Transmit done flag |
| rxd_i | input | 1 | Serial input |
| rx_en_i | input | 1 | Receive enable |
| rx_mp_i | input | 1 | Multiprocessor filter enable |
| rx_clr_i | input | 1 | Clears the receive done flag |
| rx_data_o | output | DBITS | Last accepted byte |
| rx_nine_o | output | 1 | Ninth bit of the last accepted 9-bit frame |
| rx_done_o | output | 1 | Receive done flag |

## Verification
A wrong bit counter or phase in the transmitter appears within one frame, as a shifted byte or a missing ninth bit on `txd_o`, or as `tx_done_o` rising a bit period early or late. A wrong acceptance decision appears at the next completed frame, in `rx_done_o` and `rx_data_o`: a data frame passes the filter, or a good frame is lost while the flag is clear. A broken vote or false-start check shows within about one bit time, as a phantom frame or a corrupted byte.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_8BIT = 2'b01,
    MODE_9FIX = 2'b10,
    MODE_9VAR = 2'b11
  } uart_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_NINTH, PH_STOP
  } phase_e;

  localparam int unsigned OVS = 16;
  localparam int unsigned CW  = $clog2(OVS);
endpackage

// File: rtl/uart9_strobe.sv
module uart9_strobe #(
  parameter int unsigned M2_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic fixed_i,
  input  logic dbl_i,
  output logic stb_o
);
  localparam int unsigned DW = (M2_DIV > 1) ? $clog2(M2_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(M2_DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          half_q, half_d;
  logic          raw;

  always_comb begin
    raw    = fixed_i ? (div_q == DIV_LAST) : tick_i;
    div_d  = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    half_d = raw ? ~half_q : half_q;
    stb_o  = raw & (dbl_i | half_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      half_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      half_q <= half_d;
    end
  end

  // R13
  halfrate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && !dbl_i) |=> (!stb_o || dbl_i));
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
#(
  parameter int unsigned DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  uart_mode_e       mode_i,
  input  logic             wr_i,
  input  logic [DBITS-1:0] data_i,
  input  logic             nine_i,
  input  logic             clr_i,
  output logic             txd_o,
  output logic             done_o
);
  localparam int unsigned IW = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(DBITS - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

  phase_e           st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [DBITS-1:0] sh_q, sh_d;
  logic             b9_q, b9_d, w9_q, w9_d, done_q, done_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q;
    sh_d = sh_q; b9_d = b9_q; w9_d = w9_q;
    if (st_q == PH_IDLE) begin
      if (wr_i && mode_i != MODE_OFF) begin
        st_d  = PH_START;
        cnt_d = '0;
        idx_d = '0;
        sh_d  = data_i;
        b9_d  = nine_i;
        w9_d  = (mode_i == MODE_9FIX) || (mode_i == MODE_9VAR);
      end
    end else if (stb_i) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        case (st_q)
          PH_START: st_d = PH_DATA;
          PH_DATA: begin
            sh_d = sh_q >> 1;
            if (idx_q == IDX_LAST) st_d = w9_q ? PH_NINTH : PH_STOP;
            else                   idx_d = idx_q + 1'b1;
          end
          PH_NINTH: st_d = PH_STOP;
          default:  st_d = PH_IDLE;
        endcase
      end
    end
    if (st_d == PH_STOP && st_q != PH_STOP) done_d = 1'b1;
    else if (clr_i)                         done_d = 1'b0;
    else                                    done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      b9_q <= 1'b0; w9_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; sh_q <= sh_d;
      b9_q <= b9_d; w9_q <= w9_d; done_q <= done_d;
    end
  end

  always_comb begin
    case (st_q)
      PH_START: txd_o = 1'b0;
      PH_DATA:  txd_o = sh_q[0];
      PH_NINTH: txd_o = b9_q;
      default:  txd_o = 1'b1;
    endcase
  end
  assign done_o = done_q;

  // R4
  done_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> txd_o);
  // R14
  off_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_OFF && st_q == PH_IDLE && wr_i) |=> txd_o);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_IDLE && st_q != PH_STOP && wr_i) |=> st_q != PH_IDLE);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int unsigned DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  uart_mode_e       mode_i,
  input  logic             en_i,
  input  logic             mp_i,
  input  logic             rxd_i,
  input  logic             clr_i,
  output logic [DBITS-1:0] data_o,
  output logic             nine_o,
  output logic             done_o
);
  localparam int unsigned IW = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(DBITS - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] S_A = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] S_B = CW'(OVS/2);
  localparam logic [CW-1:0] S_C = CW'(OVS/2 + 1);

  phase_e           st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [DBITS-1:0] sh_q, sh_d, data_q, data_d;
  logic [1:0]       vote_q, vote_d;
  logic             s1_q, s2_q, b9_q, b9_d, nine_q, nine_d, done_q, done_d;
  logic             wide, maj, accept;

  always_comb begin
    wide = (mode_i == MODE_9FIX) || (mode_i == MODE_9VAR);
    maj  = (vote_q[0] & vote_q[1]) | (vote_q[0] & s2_q) | (vote_q[1] & s2_q);
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; sh_d = sh_q;
    vote_d = vote_q; b9_d = b9_q; data_d = data_q; nine_d = nine_q;
    accept = 1'b0;
    if (st_q == PH_IDLE) begin
      if (en_i && mode_i != MODE_OFF && stb_i && !s2_q) begin
        st_d  = PH_START;
        cnt_d = CW'(1);
        idx_d = '0;
      end
    end else if (stb_i) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == S_A) vote_d[0] = s2_q;
      if (cnt_q == S_B) vote_d[1] = s2_q;
      if (cnt_q == S_C) begin
        case (st_q)
          PH_START: if (maj) st_d = PH_IDLE;
          PH_DATA:  sh_d = {maj, sh_q[DBITS-1:1]};
          PH_NINTH: b9_d = maj;
          default: begin
            st_d   = PH_IDLE;
            accept = !done_q && (!mp_i || (wide ? b9_q : maj));
          end
        endcase
      end
      if (cnt_q == CNT_LAST) begin
        case (st_q)
          PH_START: st_d = PH_DATA;
          PH_DATA: begin
            if (idx_q == IDX_LAST) st_d = wide ? PH_NINTH : PH_STOP;
            else                   idx_d = idx_q + 1'b1;
          end
          PH_NINTH: st_d = PH_STOP;
          default:  st_d = st_q;
        endcase
      end
    end
    if (accept) begin
      data_d = sh_q;
      if (wide) nine_d = b9_q;
    end
    if (accept)     done_d = 1'b1;
    else if (clr_i) done_d = 1'b0;
    else            done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1;
      st_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0; vote_q <= '0;
      b9_q <= 1'b0; data_q <= '0; nine_q <= 1'b0; done_q <= 1'b0;
    end else begin
      s1_q <= rxd_i; s2_q <= s1_q;
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; sh_q <= sh_d; vote_q <= vote_d;
      b9_q <= b9_d; data_q <= data_d; nine_q <= nine_d; done_q <= done_d;
    end
  end

  assign data_o = data_q;
  assign nine_o = nine_q;
  assign done_o = done_q;

  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_i) |=> $stable(data_o));
  // R8
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_o) && $past(wide && mp_i)) |-> nine_o);
  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && st_q == PH_IDLE) |=> st_q == PH_IDLE);
endmodule

// File: rtl/uart9_port.sv
module uart9_port
  import uart9_pkg::*;
#(
  parameter int unsigned DBITS  = 8,
  parameter int unsigned M2_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             dbl_i,
  input  logic             tick16_i,
  input  logic             tx_wr_i,
  input  logic [DBITS-1:0] tx_data_i,
  input  logic             tx_nine_i,
  input  logic             tx_clr_i,
  output logic             txd_o,
  output logic             tx_done_o,
  input  logic             rxd_i,
  input  logic             rx_en_i,
  input  logic             rx_mp_i,
  input  logic             rx_clr_i,
  output logic [DBITS-1:0] rx_data_o,
  output logic             rx_nine_o,
  output logic             rx_done_o
);
  uart_mode_e mode;
  logic       stb;

  assign mode = uart_mode_e'(mode_i);

  uart9_strobe #(.M2_DIV(M2_DIV)) u_stb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick16_i),
    .fixed_i(mode == MODE_9FIX), .dbl_i(dbl_i), .stb_o(stb)
  );

  uart9_tx #(.DBITS(DBITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .mode_i(mode),
    .wr_i(tx_wr_i), .data_i(tx_data_i), .nine_i(tx_nine_i),
    .clr_i(tx_clr_i), .txd_o(txd_o), .done_o(tx_done_o)
  );

  uart9_rx #(.DBITS(DBITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .mode_i(mode),
    .en_i(rx_en_i), .mp_i(rx_mp_i), .rxd_i(rxd_i), .clr_i(rx_clr_i),
    .data_o(rx_data_o), .nine_o(rx_nine_o), .done_o(rx_done_o)
  );
endmodule

// File: tb/sim_uart9_port.sv
module sim_uart9_port;
  localparam int M2 = 4;
  localparam int NV = 13;
  // {is_rx, mode[1:0], dbl, mp, nine, stop, data[7:0], exp_ok}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b1},
    {1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1},
    {1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'h5A, 1'b0},
    {1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b1},
    {1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 1'b1},
    {1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b0},
    {1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 1'b1},
    {1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1},
    {1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h96, 1'b1},
    {1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h4B, 1'b1},
    {1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'hF0, 1'b1},
    {1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, 1'b1},
    {1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic dbl = 1'b1, tick = 1'b1, tx_wr = 1'b0, tx_nine = 1'b0, tx_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic rxd = 1'b1, rx_en = 1'b1, rx_mp = 1'b0, rx_clr = 1'b0;
  logic txd, tx_done, rx_nine, rx_done;
  logic [7:0] rx_data;
  int checks = 0, fails = 0, tdiv = 1;
  logic [7:0] exp_data = 8'h00;
  logic exp_nine = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  uart9_port #(.DBITS(8), .M2_DIV(M2)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .dbl_i(dbl), .tick16_i(tick),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_nine_i(tx_nine), .tx_clr_i(tx_clr),
    .txd_o(txd), .tx_done_o(tx_done), .rxd_i(rxd), .rx_en_i(rx_en),
    .rx_mp_i(rx_mp), .rx_clr_i(rx_clr), .rx_data_o(rx_data),
    .rx_nine_o(rx_nine), .rx_done_o(rx_done)
  );

  initial begin : tick_gen
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick = ((tc % tdiv) == 0);
    end
  end

  function automatic int bper(input logic [1:0] md, input logic db);
    return 16 * ((md == 2'b10) ? M2 : tdiv) * (db ? 1 : 2);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic tx_frame(input logic [1:0] md, input logic db, input logic n9,
                          input logic [7:0] d, input logic rewrite, input string req);
    int b, w, lows;
    logic [7:0] got;
    logic g9;
    b = bper(md, db);
    @(negedge clk);
    mode = md; dbl = db; tx_nine = n9; tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    w = 0;
    while (txd && w < 4 * b) begin @(negedge clk); w++; end
    chk(!txd, {req, " start edge"}, txd, 0);
    if (rewrite) begin
      tx_data = ~d; tx_nine = ~n9; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
      repeat (b/2 - 1) @(negedge clk);
    end else repeat (b/2) @(negedge clk);
    chk(!txd, {req, " start bit"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (b) @(negedge clk);
      got[i] = txd;
    end
    g9 = 1'b0;
    if (md[1]) begin
      repeat (b) @(negedge clk);
      g9 = txd;
    end
    chk(!tx_done, "R4 done low before stop", tx_done, 0);
    repeat (b) @(negedge clk);
    chk(txd, {req, " stop bit"}, txd, 1);
    chk(tx_done, "R4 done at stop", tx_done, 1);
    chk(got == d, {req, " data"}, got, d);
    if (md[1]) chk(g9 == n9, "R3 ninth bit", g9, n9);
    lows = 0;
    repeat (2 * b) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, rewrite ? "R5 no second frame" : {req, " idle after"}, lows, 0);
    chk(tx_done, "R4 done held", tx_done, 1);
    tx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0;
    @(negedge clk);
    chk(!tx_done, "R4 done cleared", tx_done, 0);
  endtask

  task automatic rx_frame(input logic [1:0] md, input logic db, input logic mp,
                          input logic n9, input logic sb, input logic [7:0] d,
                          input logic glitch, input logic exp_ok,
                          input logic keep, input string req);
    int b;
    b = bper(md, db);
    @(negedge clk);
    mode = md; dbl = db; rx_mp = mp;
    repeat (4) @(negedge clk);
    rxd = 1'b0;
    repeat (b) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      if (glitch && i == 3) begin
        repeat (b/2) @(negedge clk);
        rxd = ~d[i];
        @(negedge clk);
        rxd = d[i];
        repeat (b - b/2 - 1) @(negedge clk);
      end else repeat (b) @(negedge clk);
    end
    if (md[1]) begin rxd = n9; repeat (b) @(negedge clk); end
    rxd = sb;
    repeat (b) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * b) @(negedge clk);
    if (exp_ok) begin
      exp_data = d;
      if (md[1]) exp_nine = n9;
    end
    chk(rx_done == (exp_ok || keep), {req, " done flag"}, rx_done, exp_ok || keep);
    chk(rx_data == exp_data, {req, " data"}, rx_data, exp_data);
    chk(rx_nine == exp_nine, {req, " ninth"}, rx_nine, exp_nine);
    if (!keep) begin
      rx_clr = 1'b1;
      @(negedge clk);
      rx_clr = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin : main
    string rq;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd, "R1 txd", txd, 1);
    chk(!tx_done && !rx_done, "R1 flags", {tx_done, rx_done}, 0);
    chk(rx_data == 8'h00 && !rx_nine, "R1 rx regs", {rx_nine, rx_data}, 0);

    // table walk; dbl=0 rows also cover R13
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      if (v[15]) begin
        rq = !v[0] ? (v[14] ? "R8" : "R9") : (v[14] ? "R7" : "R6");
        rx_frame(v[14:13], v[12], v[11], v[10], v[9], v[8:1], 1'b0, v[0], 1'b0, rq);
      end else begin
        rq = v[14] ? "R3" : "R2";
        tx_frame(v[14:13], v[12], v[10], v[8:1], 1'b0, rq);
      end
    end

    // R5 write during busy frame
    tx_frame(2'b11, 1'b1, 1'b1, 8'h6D, 1'b1, "R5");

    // R13 external tick every third clock
    tdiv = 3;
    tx_frame(2'b01, 1'b1, 1'b0, 8'hB2, 1'b0, "R13");
    rx_frame(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h4D, 1'b0, 1'b1, 1'b0, "R13");
    tdiv = 1;

    // R10 receiver disabled
    rx_en = 1'b0;
    rx_frame(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE7, 1'b0, 1'b0, 1'b0, "R10");
    rx_en = 1'b1;

    // R11 flag still set: second frame dropped
    rx_frame(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h19, 1'b0, 1'b1, 1'b1, "R11");
    rx_frame(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h91, 1'b0, 1'b0, 1'b1, "R11");
    rx_clr = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0;
    @(negedge clk);
    chk(!rx_done, "R11 flag cleared", rx_done, 0);

    // R12 glitch inside data bit 3 is outvoted
    rx_frame(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5C, 1'b1, 1'b1, 1'b0, "R12");
    // R12 false start: short low pulse
    mode = 2'b01; dbl = 1'b1;
    @(negedge clk);
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk(!rx_done, "R12 false start", rx_done, 0);
    chk(rx_data == exp_data, "R12 data kept", rx_data, exp_data);

    // R14 mode off
    begin : off_mode
      int lows;
      lows = 0;
      mode = 2'b00;
      tx_data = 8'h00; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
      repeat (200) begin @(negedge clk); if (!txd) lows++; end
      chk(lows == 0, "R14 txd idle", lows, 0);
      chk(!tx_done, "R14 no tx flag", tx_done, 0);
    end
    rx_frame(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3E, 1'b0, 1'b0, 1'b0, "R14");

    summary();
  end
endmodule